// File: doc/BRIEF.md
# 4:2:2 Pixel Port Formatter

This block turns a byte stream of 4:2:2 video samples into the drive for a 16-bit output data port and its line-locked output clock. Samples arrive one per full-rate clock through a valid/ready input. Each sample carries a flag that marks it as luma or chroma. The expected order within a pixel pair is Cb, Y0, Cr, Y1. The block collects one complete pair and then emits it over the next four full-rate cycles. It does this in one of two lane layouts, chosen by a 4-bit format code.

The first layout is a narrow interleaved mode: one byte per clock on the upper lane, and the lower lane released. The second is a wide mode: one word every two clocks, with luma on the upper lane and chroma on the lower lane. Per-lane output enables stand in for three-state pins. Any code other than the two defined ones releases both lanes.

Three further controls shape the output. One swaps the two chroma samples of a pair. One selects whether the clock pin carries the full-rate clock or a half-rate clock that is synchronous with the data. One inverts that clock. All four controls are sampled only when a pair starts to be emitted, so a pair is never split across two configurations.

Top module: `pxp_formatter`

## Requirements
- R1: While `rst_n` is low, `s_ready`, both output enables and all of `pdata` are 0. After reset is released, `s_ready` is 1 from the next clock on.
- R2: With format code 4'b0011, the four cycles of a pair carry Cb, Y0, Cr, Y1 in that order on `pdata[15:8]`. In those cycles `pdata_oe_hi` is 1, `pdata_oe_lo` is 0 and `pdata[7:0]` is 0.
- R3: With format code 4'b0010, `pdata` holds {Y0, Cb} for the first two cycles of a pair and {Y1, Cr} for the last two. Both enables are 1.
- R4: Any format code other than 4'b0011 and 4'b0010 leaves both enables at 0 and `pdata` at 0 for the whole pair.
- R5: With `chroma_swap` at 1, Cr takes the place of Cb and Cb the place of Cr in both lane layouts. With `chroma_swap` at 0, the order of R2 and R3 applies.
- R6: With `clk_pad_sel` at 3'b101, `pclk_out` is a half-rate clock: low in pair cycles 0 and 2, high in the Y cycles 1 and 3. With any other value, `pclk_out` follows `clk`.
- R7: With `clk_invert` at 1, `pclk_out` is the complement of what R6 gives.
- R8: The format code, chroma swap, clock select and clock invert take effect only when a pair is loaded for emission. A change during a pair has no effect until the next pair starts.
- R9: A pair opens on a chroma-flagged sample and needs Y, C, Y to follow in turn. A chroma sample out of order restarts the pair as its Cb. A luma sample out of order discards the open pair. Emission begins in the cycle after the fourth sample is accepted. With no pair in emission, both enables are 0 and `pdata` is 0.
- R10: The half-rate clock phase restarts at each pair load, so that pair cycle 0 always begins on the low (non-inverted) half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Full-rate sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_valid | input | 1 | Input sample valid |
| s_ready | output | 1 | Input sample accepted when high |
| s_data | input | 8 | Input sample byte |
| s_is_luma | input | 1 | 1 for a Y sample, 0 for a Cb/Cr sample |
| fmt_sel | input | 4 | Lane layout code (0011 narrow, 0010 wide) |
| chroma_swap | input | 1 | Exchange Cb and Cr within each pair |
| clk_pad_sel | input | 3 | 101 selects half-rate output clock |
| clk_invert | input | 1 | Invert the output clock |
| pdata | output | 16 | Output data port |
| pdata_oe_hi | output | 1 | Drive enable for pdata[15:8] |
| pdata_oe_lo | output | 1 | Drive enable for pdata[7:0] |
| pclk_out | output | 1 | Output line-lock clock |

## Verification
The assertions watch several properties on every cycle. A released upper lane must carry zeros, and the narrow mode keeps the lower byte at zero. Wide words hold across their second cycle. The latched controls move only at a pair load, and each load restarts the emission slot and the half-rate phase. Other behaviour depends on the data values and on what happened earlier in the stream, and only the bench's scenarios can show it. This covers the byte order within a pair, the chroma swap, and recovery from misframed input. It also covers the half-rate and inverted clock levels and the one-pair delay before a control change takes effect. The bench's cycle model checks all of these against the ports.

// File: rtl/pxp_pkg.sv
package pxp_pkg;
  localparam int SAMPLE_W = 8;
  localparam int FMT_W    = 4;
  localparam int PAD_W    = 3;
  localparam int PAIR_LEN = 4;
  localparam int SLOT_W   = $clog2(PAIR_LEN);
  localparam int PORT_W   = 2 * SAMPLE_W;

  localparam logic [FMT_W-1:0] FMT_NARROW = 4'b0011;
  localparam logic [FMT_W-1:0] FMT_WIDE   = 4'b0010;
  localparam logic [PAD_W-1:0] PAD_FULL   = 3'b000;
  localparam logic [PAD_W-1:0] PAD_HALF   = 3'b101;

  typedef struct packed {
    logic [SAMPLE_W-1:0] cb;
    logic [SAMPLE_W-1:0] y0;
    logic [SAMPLE_W-1:0] cr;
    logic [SAMPLE_W-1:0] y1;
  } pxp_pair_t;

  typedef struct packed {
    logic                oe_hi;
    logic                oe_lo;
    logic [SAMPLE_W-1:0] hi;
    logic [SAMPLE_W-1:0] lo;
  } pxp_lanes_t;

  function automatic logic is_narrow(logic [FMT_W-1:0] f);
    return f == FMT_NARROW;
  endfunction

  function automatic logic is_wide(logic [FMT_W-1:0] f);
    return f == FMT_WIDE;
  endfunction

  // chroma of the first (second=0) or second half of the pair, after swap
  function automatic logic [SAMPLE_W-1:0] pick_chroma(pxp_pair_t p, logic second, logic swap);
    return (second ^ swap) ? p.cr : p.cb;
  endfunction

  function automatic logic [SAMPLE_W-1:0] pick_luma(pxp_pair_t p, logic second);
    return second ? p.y1 : p.y0;
  endfunction

  function automatic pxp_lanes_t lane_map(pxp_pair_t p, logic [SLOT_W-1:0] slot,
                                          logic [FMT_W-1:0] f, logic swap, logic act);
    pxp_lanes_t l;
    l = '0;
    if (act && is_narrow(f)) begin
      l.oe_hi = 1'b1;
      l.hi    = slot[0] ? pick_luma(p, slot[1]) : pick_chroma(p, slot[1], swap);
    end else if (act && is_wide(f)) begin
      l.oe_hi = 1'b1;
      l.oe_lo = 1'b1;
      l.hi    = pick_luma(p, slot[1]);
      l.lo    = pick_chroma(p, slot[1], swap);
    end
    return l;
  endfunction
endpackage

// File: rtl/pxp_pair_collect.sv
module pxp_pair_collect
  import pxp_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                accept,
  input  logic [SAMPLE_W-1:0] in_data,
  input  logic                in_luma,
  output logic                pair_done,
  output pxp_pair_t           pair_out
);
  logic [SLOT_W-1:0]   idx;
  logic [SAMPLE_W-1:0] cb_q, y0_q, cr_q;
  logic                phase_ok;

  // even positions expect chroma, odd positions expect luma
  assign phase_ok  = (in_luma == idx[0]);
  assign pair_done = accept && phase_ok && (idx == SLOT_W'(PAIR_LEN - 1));
  assign pair_out  = '{cb: cb_q, y0: y0_q, cr: cr_q, y1: in_data};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx  <= '0;
      cb_q <= '0;
      y0_q <= '0;
      cr_q <= '0;
    end else if (accept) begin
      if (phase_ok) begin
        case (idx)
          2'd0:    cb_q <= in_data;
          2'd1:    y0_q <= in_data;
          2'd2:    cr_q <= in_data;
          default: ;
        endcase
        idx <= idx + 1'b1;
      end else if (!in_luma) begin
        cb_q <= in_data;
        idx  <= SLOT_W'(1);
      end else begin
        idx <= '0;
      end
    end
  end
endmodule

// File: rtl/pxp_emitter.sv
module pxp_emitter
  import pxp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  pxp_pair_t         pair_in,
  input  logic [FMT_W-1:0]  fmt_in,
  input  logic              swap_in,
  input  logic [PAD_W-1:0]  pad_in,
  input  logic              inv_in,
  output pxp_lanes_t        lanes,
  output logic              active,
  output logic [SLOT_W-1:0] slot,
  output logic              half_phase,
  output logic [FMT_W-1:0]  lat_fmt,
  output logic [PAD_W-1:0]  lat_pad,
  output logic              lat_inv
);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(PAIR_LEN - 1);

  pxp_pair_t pair_q;
  logic      lat_swap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pair_q     <= '0;
      lat_fmt    <= FMT_NARROW;
      lat_swap   <= 1'b0;
      lat_pad    <= PAD_FULL;
      lat_inv    <= 1'b0;
      active     <= 1'b0;
      slot       <= '0;
      half_phase <= 1'b0;
    end else if (load) begin
      pair_q     <= pair_in;
      lat_fmt    <= fmt_in;
      lat_swap   <= swap_in;
      lat_pad    <= pad_in;
      lat_inv    <= inv_in;
      active     <= 1'b1;
      slot       <= '0;
      half_phase <= 1'b0;
    end else begin
      half_phase <= ~half_phase;
      if (active) begin
        slot <= slot + 1'b1;
        if (slot == LAST_SLOT) active <= 1'b0;
      end
    end
  end

  assign lanes = lane_map(pair_q, slot, lat_fmt, lat_swap, active);
endmodule

// File: rtl/pxp_clk_sel.sv
module pxp_clk_sel
  import pxp_pkg::*;
(
  input  logic             clk,
  input  logic             half_phase,
  input  logic [PAD_W-1:0] pad_sel,
  input  logic             invert,
  output logic             pclk
);
  logic use_half;
  assign use_half = (pad_sel == PAD_HALF);
  assign pclk     = (use_half ? half_phase : clk) ^ invert;
endmodule

// File: rtl/pxp_formatter.sv
module pxp_formatter
  import pxp_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                s_valid,
  output logic                s_ready,
  input  logic [SAMPLE_W-1:0] s_data,
  input  logic                s_is_luma,
  input  logic [FMT_W-1:0]    fmt_sel,
  input  logic                chroma_swap,
  input  logic [PAD_W-1:0]    clk_pad_sel,
  input  logic                clk_invert,
  output logic [PORT_W-1:0]   pdata,
  output logic                pdata_oe_hi,
  output logic                pdata_oe_lo,
  output logic                pclk_out
);
  logic              ready_q;
  logic              accept;
  logic              pair_load;
  pxp_pair_t         pair_next;
  pxp_lanes_t        lanes;
  logic              emit_active;
  logic [SLOT_W-1:0] emit_slot;
  logic              half_phase;
  logic [FMT_W-1:0]  lat_fmt;
  logic [PAD_W-1:0]  lat_pad;
  logic              lat_inv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ready_q <= 1'b0;
    else        ready_q <= 1'b1;
  end

  assign s_ready = ready_q;
  assign accept  = s_valid && ready_q;

  pxp_pair_collect u_collect (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .in_data   (s_data),
    .in_luma   (s_is_luma),
    .pair_done (pair_load),
    .pair_out  (pair_next)
  );

  pxp_emitter u_emit (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (pair_load),
    .pair_in    (pair_next),
    .fmt_in     (fmt_sel),
    .swap_in    (chroma_swap),
    .pad_in     (clk_pad_sel),
    .inv_in     (clk_invert),
    .lanes      (lanes),
    .active     (emit_active),
    .slot       (emit_slot),
    .half_phase (half_phase),
    .lat_fmt    (lat_fmt),
    .lat_pad    (lat_pad),
    .lat_inv    (lat_inv)
  );

  pxp_clk_sel u_clk (
    .clk        (clk),
    .half_phase (half_phase),
    .pad_sel    (lat_pad),
    .invert     (lat_inv),
    .pclk       (pclk_out)
  );

  assign pdata       = {lanes.hi, lanes.lo};
  assign pdata_oe_hi = lanes.oe_hi;
  assign pdata_oe_lo = lanes.oe_lo;
endmodule

// File: rtl/pxp_formatter_chk.sv
module pxp_formatter_chk
  import pxp_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              s_ready,
  input logic [PORT_W-1:0] pdata,
  input logic              pdata_oe_hi,
  input logic              pdata_oe_lo,
  input logic              pair_load,
  input logic              emit_active,
  input logic [SLOT_W-1:0] emit_slot,
  input logic              half_phase,
  input logic [FMT_W-1:0]  lat_fmt
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |=> (!s_ready && !pdata_oe_hi && !pdata_oe_lo && pdata == '0));

  // R2
  narrow_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pdata_oe_hi && !pdata_oe_lo) |-> (pdata[SAMPLE_W-1:0] == '0));

  // R4
  released_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pdata_oe_hi |-> (pdata == '0 && !pdata_oe_lo));

  // R3
  wide_word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (emit_active && emit_slot[0] && lat_fmt == FMT_WIDE) |-> $stable(pdata));

  // R8
  ctl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pair_load |=> $stable(lat_fmt));

  // R9
  load_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pair_load |=> (emit_active && emit_slot == '0));

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !emit_active |-> (!pdata_oe_hi && !pdata_oe_lo));

  // R10
  phase_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pair_load |=> !half_phase);
endmodule

bind pxp_formatter pxp_formatter_chk chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .s_ready     (s_ready),
  .pdata       (pdata),
  .pdata_oe_hi (pdata_oe_hi),
  .pdata_oe_lo (pdata_oe_lo),
  .pair_load   (pair_load),
  .emit_active (emit_active),
  .emit_slot   (emit_slot),
  .half_phase  (half_phase),
  .lat_fmt     (lat_fmt)
);

// File: tb/pxp_formatter_tb_top.sv
`timescale 1ns/1ps
module pxp_formatter_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        s_valid;
  logic        s_ready;
  logic [7:0]  s_data;
  logic        s_is_luma;
  logic [3:0]  fmt_sel;
  logic        chroma_swap;
  logic [2:0]  clk_pad_sel;
  logic        clk_invert;
  logic [15:0] pdata;
  logic        pdata_oe_hi;
  logic        pdata_oe_lo;
  logic        pclk_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  pxp_formatter dut_i (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
    .s_data(s_data), .s_is_luma(s_is_luma), .fmt_sel(fmt_sel),
    .chroma_swap(chroma_swap), .clk_pad_sel(clk_pad_sel), .clk_invert(clk_invert),
    .pdata(pdata), .pdata_oe_hi(pdata_oe_hi), .pdata_oe_lo(pdata_oe_lo),
    .pclk_out(pclk_out)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp, string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // behavioural reference model
  logic [7:0] frag[$];
  logic [7:0] m_pair[4];
  bit   m_rdy, m_act, m_hph, m_swap, m_inv;
  int   m_slot;
  logic [3:0] m_fmt;
  logic [2:0] m_pad;
  int   edges = 0;

  always @(posedge clk) begin
    edges++;
    if (!rst_n) begin
      frag.delete();
      m_rdy = 0; m_act = 0; m_hph = 0; m_slot = 0;
      m_fmt = 4'b0011; m_swap = 0; m_pad = 3'b000; m_inv = 0;
    end else begin
      bit full;
      full = 0;
      if (s_valid && m_rdy) begin
        if ((frag.size() % 2 == 1) == s_is_luma) begin
          frag.push_back(s_data);
          if (frag.size() == 4) full = 1;
        end else if (!s_is_luma) begin
          frag.delete();
          frag.push_back(s_data);
        end else frag.delete();
      end
      if (full) begin
        foreach (m_pair[i]) m_pair[i] = frag[i];
        frag.delete();
        m_fmt = fmt_sel; m_swap = chroma_swap; m_pad = clk_pad_sel; m_inv = clk_invert;
        m_act = 1; m_slot = 0; m_hph = 0;
      end else begin
        m_hph = !m_hph;
        if (m_act) begin
          if (m_slot == 3) m_act = 0;
          m_slot = (m_slot + 1) % 4;
        end
      end
      m_rdy = 1;
    end
  end

  always @(negedge clk) begin
    #1;
    if (edges > 0 && !done) begin
      logic [15:0] ed; logic eh, el, ep; string rq;
      ed = '0; eh = 0; el = 0;
      if (!m_act) rq = "R9";
      else if (m_fmt == 4'b0011) begin
        eh = 1; rq = m_swap ? "R5" : "R2";
        if (m_slot % 2 == 1) ed[15:8] = m_pair[m_slot];
        else ed[15:8] = m_pair[((m_slot == 2) != m_swap) ? 2 : 0];
      end else if (m_fmt == 4'b0010) begin
        eh = 1; el = 1; rq = m_swap ? "R5" : "R3";
        ed[15:8] = m_pair[(m_slot < 2) ? 1 : 3];
        ed[7:0]  = m_pair[((m_slot < 2) != m_swap) ? 0 : 2];
      end else rq = "R4";
      if (!rst_n) rq = "R1";
      check(rq, {14'd0, pdata_oe_hi, pdata_oe_lo, pdata}, {14'd0, eh, el, ed}, "lanes");
      ep = ((m_pad == 3'b101) ? m_hph : 1'b0) ^ m_inv;
      check(m_inv ? "R7" : "R6", {31'd0, pclk_out}, {31'd0, ep}, "pclk low phase");
    end
  end

  task automatic send(logic [7:0] d, logic luma);
    s_valid = 1; s_data = d; s_is_luma = luma;
    @(negedge clk);
    s_valid = 0;
  endtask

  task automatic send_pair(logic [7:0] cb, logic [7:0] y0, logic [7:0] cr, logic [7:0] y1);
    send(cb, 0); send(y0, 1); send(cr, 0); send(y1, 1);
  endtask

  task automatic idle(int n);
    s_valid = 0;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    rst_n = 0; s_valid = 0; s_data = 0; s_is_luma = 0;
    fmt_sel = 4'b0011; chroma_swap = 0; clk_pad_sel = 3'b000; clk_invert = 0;
    repeat (4) @(negedge clk);
    #1;
    check("R1", {31'd0, s_ready}, 32'd0, "ready in reset");
    check("R1", {14'd0, pdata_oe_hi, pdata_oe_lo, pdata}, 32'd0, "outputs in reset");
    rst_n = 1;
    @(negedge clk); #1;
    check("R1", {31'd0, s_ready}, 32'd1, "ready after reset");
    @(negedge clk);

    // R2 narrow default order, back to back pairs
    send_pair(8'h10, 8'h11, 8'h12, 8'h13);
    #1 check("R2", {24'd0, pdata[15:8]}, 32'h10, "narrow slot0 Cb");
    send_pair(8'h20, 8'h21, 8'h22, 8'h23);
    send_pair(8'h30, 8'h31, 8'h32, 8'h33);
    idle(6);

    // R5 swap in narrow mode
    chroma_swap = 1;
    send_pair(8'h40, 8'h41, 8'h42, 8'h43);
    #1 check("R5", {24'd0, pdata[15:8]}, 32'h42, "swapped slot0 Cr");
    idle(5);

    // R3 wide mode, full-rate clock
    chroma_swap = 0; fmt_sel = 4'b0010;
    send_pair(8'h50, 8'h51, 8'h52, 8'h53);
    #1 check("R3", {16'd0, pdata}, 32'h5150, "wide word 0");
    @(posedge clk); #1;
    check("R6", {31'd0, pclk_out}, 32'd1, "full-rate clock high phase");
    @(negedge clk);
    send_pair(8'h60, 8'h61, 8'h62, 8'h63);
    idle(5);

    // R6 R10 half-rate clock in wide mode
    clk_pad_sel = 3'b101;
    send_pair(8'h70, 8'h71, 8'h72, 8'h73);
    #1 check("R10", {31'd0, pclk_out}, 32'd0, "half clock low at slot0");
    @(negedge clk); #1;
    check("R6", {31'd0, pclk_out}, 32'd1, "half clock high at Y slot");
    @(negedge clk);
    // R7 inverted half clock, swap in wide mode
    clk_invert = 1; chroma_swap = 1;
    send_pair(8'h80, 8'h81, 8'h82, 8'h83);
    #1 check("R7", {31'd0, pclk_out}, 32'd1, "inverted half clock at slot0");
    check("R5", {16'd0, pdata}, 32'h8182, "wide swapped word 0");
    send_pair(8'h90, 8'h91, 8'h92, 8'h93);
    idle(7);
    clk_invert = 0; chroma_swap = 0; clk_pad_sel = 3'b011;

    // R8 mid-pair control change
    fmt_sel = 4'b0011;
    send_pair(8'hA0, 8'hA1, 8'hA2, 8'hA3);
    fmt_sel = 4'b0010; clk_invert = 1;
    @(negedge clk); #1;
    check("R8", {30'd0, pdata_oe_hi, pdata_oe_lo}, 32'd2, "old format held mid-pair");
    check("R8", {24'd0, pdata[15:8]}, 32'hA1, "old format byte mid-pair");
    idle(4);
    clk_invert = 0;

    // R4 reserved and undefined codes
    fmt_sel = 4'b0110;
    send_pair(8'hB0, 8'hB1, 8'hB2, 8'hB3);
    #1 check("R4", {30'd0, pdata_oe_hi, pdata_oe_lo}, 32'd0, "reserved 0110 released");
    fmt_sel = 4'b1111;
    send_pair(8'hB4, 8'hB5, 8'hB6, 8'hB7);
    fmt_sel = 4'b0000;
    send_pair(8'hB8, 8'hB9, 8'hBA, 8'hBB);
    #1 check("R4", {16'd0, pdata}, 32'd0, "undefined 0000 zero data");
    idle(5);

    // R9 misframed input
    fmt_sel = 4'b0011;
    send(8'hC0, 1); send(8'hC1, 1); send(8'hC2, 0); send(8'hC3, 1); send(8'hC4, 0);
    send(8'hC5, 0); send(8'hC6, 1); send(8'hC7, 0); send(8'hC8, 1);
    #1 check("R9", {24'd0, pdata[15:8]}, 32'hC5, "restart on early chroma");
    idle(5);
    send(8'hD0, 0); send(8'hD1, 1); send(8'hD2, 1);
    idle(3);
    #1 check("R9", {31'd0, pdata_oe_hi}, 32'd0, "broken pair not emitted");
    // gaps between samples
    send(8'hE0, 0); idle(2); send(8'hE1, 1); send(8'hE2, 0); idle(1); send(8'hE3, 1);
    #1 check("R9", {24'd0, pdata[15:8]}, 32'hE0, "gapped pair slot0");
    idle(8);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule